// File: doc/BRIEF.md
# Extended-Precision Add/Subtract Flag Unit

This block performs one step of a multiprecision addition or subtraction. Each operation takes a source and a destination operand at byte, word or long width. An add computes destination plus source plus a stored extend bit. A subtract computes destination minus source minus that bit. The sized result is merged into the destination register value, so the bits above the selected width keep the destination's contents. The result is registered together with a five-bit condition code.

The extend bit lives in the condition code register and is loaded with the same value as carry. A wide number can therefore be processed least-significant word first, one operation per word, and the carry or borrow of each step flows into the next. Both the operand width and the carry-chaining structure are parameters.

Top module: `xau_top`

## Requirements
- R1: On a valid add, the sized result equals (dst + src + X) truncated to the selected width, where X is the stored extend flag (ccr_o bit 4).
- R2: On a valid subtract (op_sub_i = 1), the sized result equals (dst - src - X) truncated to the selected width.
- R3: size_i selects the operand width: 00 byte (low DATA_W/4 bits), 01 word (low DATA_W/2 bits), 10 and 11 long (all DATA_W bits). Within result_o, the bits above the selected width are copied from dst_i.
- R4: Carry (ccr_o bit 0) is the carry out of the selected width for an add, and the borrow out of the selected width for a subtract. It is set when the main step or the extend step carries or borrows.
- R5: After every valid operation, extend (ccr_o bit 4) equals carry (ccr_o bit 0).
- R6: Negative (ccr_o bit 3) is the most significant bit of the sized result.
- R7: Zero (ccr_o bit 2) is set exactly when the sized result is zero. It is recomputed on every operation and does not depend on its previous value.
- R8: Overflow (ccr_o bit 1) for an add is set when dst and src have the same sign and the sign of the result differs from it. For a subtract it is set when dst and src have different signs and the sign of the result differs from the sign of dst. All signs are taken at the selected width.
- R9: The condition code layout is X = bit 4, N = bit 3, Z = bit 2, V = bit 1, C = bit 0.
- R10: result_o and ccr_o change only on the clock edge after a cycle with valid_i high. While valid_i is low, both hold their values whatever the other inputs do.
- R11: A synchronous reset (rst high at a clock edge) clears ccr_o and result_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Single-cycle strobe: perform the operation on this cycle's inputs |
| op_sub_i | input | 1 | 0 = add with extend, 1 = subtract with extend |
| size_i | input | 2 | Operand width: 00 byte, 01 word, 10/11 long |
| src_i | input | DATA_W | Source operand |
| dst_i | input | DATA_W | Destination register value |
| result_o | output | DATA_W | Destination register value after write-back |
| ccr_o | output | 5 | Condition code {X, N, Z, V, C} |

## Verification
The assertions check the following on every cycle:
- outputs hold while no strobe is present, and reset clears the register;
- after a strobe, extend matches carry, and zero and negative agree with the registered sized result;
- upper destination bits survive a byte operation.

Only the bench's scenarios can show that the arithmetic values, carry, borrow and overflow are correct, because that needs an independent reference model. The scenarios include:
- the known byte cases;
- a 64-bit value added in two chained long steps;
- the reserved size code;
- a long pseudo-random sequence in which the extend bit is carried from one operation to the next.

// File: rtl/xau_pkg.sv
`timescale 1ns/1ps
package xau_pkg;

   typedef enum logic [1:0] {
      XAU_SZ_BYTE = 2'b00,
      XAU_SZ_WORD = 2'b01,
      XAU_SZ_LONG = 2'b10,
      XAU_SZ_WIDE = 2'b11
   } xau_size_e;

   localparam int XAU_CCR_W = 5;
   localparam int XAU_BIT_X = 4;
   localparam int XAU_BIT_N = 3;
   localparam int XAU_BIT_Z = 2;
   localparam int XAU_BIT_V = 1;
   localparam int XAU_BIT_C = 0;

   localparam int XAU_LANES = 3;

   typedef struct packed {
      logic carry;
      logic ovf;
      logic neg;
      logic zero;
   } xau_flag_s;

endpackage

// File: rtl/xau_slice.sv
`timescale 1ns/1ps
module xau_slice
   import xau_pkg::*;
#(
   parameter int W              = 8,
   parameter bit TWO_STEP_CARRY = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         x_i,
   output logic [W-1:0] res_o,
   output xau_flag_s    flags_o
);

   if (W < 2) begin : g_bad_width
      $error("xau_slice: W must be at least 2");
   end

   logic [W-1:0] res;
   logic         carry;

   if (TWO_STEP_CARRY) begin : g_two_step
      logic [W:0] step1;
      logic [W:0] step2;
      always_comb begin
         if (sub_i) begin
            step1 = {1'b0, a_i} - {1'b0, b_i};
            step2 = {1'b0, step1[W-1:0]} - (W+1)'(x_i);
         end else begin
            step1 = {1'b0, a_i} + {1'b0, b_i};
            step2 = {1'b0, step1[W-1:0]} + (W+1)'(x_i);
         end
      end
      assign res   = step2[W-1:0];
      assign carry = step1[W] | step2[W];
   end else begin : g_one_step
      logic [W-1:0] b_eff;
      logic         cin;
      logic [W:0]   sum;
      assign b_eff = sub_i ? ~b_i : b_i;
      assign cin   = sub_i ? ~x_i : x_i;
      assign sum   = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(cin);
      assign res   = sum[W-1:0];
      assign carry = sub_i ? ~sum[W] : sum[W];
   end

   logic sign_a, sign_b, sign_r;
   assign sign_a = a_i[W-1];
   assign sign_b = b_i[W-1];
   assign sign_r = res[W-1];

   assign res_o         = res;
   assign flags_o.carry = carry;
   assign flags_o.neg   = sign_r;
   assign flags_o.zero  = ~|res;
   assign flags_o.ovf   = sub_i ? ((sign_a != sign_b) && (sign_r != sign_a))
                                : ((sign_a == sign_b) && (sign_r != sign_a));

endmodule

// File: rtl/xau_ccr.sv
`timescale 1ns/1ps
module xau_ccr
   import xau_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load_i,
   input  xau_flag_s            flags_i,
   output logic [XAU_CCR_W-1:0] ccr_o
);

   logic [XAU_CCR_W-1:0] ccr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ccr_q <= '0;
      end else if (load_i) begin
         ccr_q[XAU_BIT_X] <= flags_i.carry;
         ccr_q[XAU_BIT_N] <= flags_i.neg;
         ccr_q[XAU_BIT_Z] <= flags_i.zero;
         ccr_q[XAU_BIT_V] <= flags_i.ovf;
         ccr_q[XAU_BIT_C] <= flags_i.carry;
      end
   end

   assign ccr_o = ccr_q;

   // R11: reset clears the flags
   a_r11_ccr_clear: assert property (@(posedge clk) rst |=> (ccr_o == '0));

   // R10: no load, no change
   a_r10_ccr_hold: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(ccr_o));

endmodule

// File: rtl/xau_top.sv
`timescale 1ns/1ps
module xau_top
   import xau_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter bit TWO_STEP_CARRY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 valid_i,
   input  logic                 op_sub_i,
   input  logic [1:0]           size_i,
   input  logic [DATA_W-1:0]    src_i,
   input  logic [DATA_W-1:0]    dst_i,
   output logic [DATA_W-1:0]    result_o,
   output logic [XAU_CCR_W-1:0] ccr_o
);

   localparam int BYTE_W = DATA_W / 4;
   localparam int WORD_W = DATA_W / 2;

   if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("xau_top: DATA_W must be a multiple of 4 and at least 8");
   end

   logic [DATA_W-1:0] lane_wb  [XAU_LANES];
   xau_flag_s         lane_flg [XAU_LANES];
   logic              x_now;

   assign x_now = ccr_o[XAU_BIT_X];

   for (genvar i = 0; i < XAU_LANES; i++) begin : g_lane
      localparam int LW = DATA_W >> (XAU_LANES - 1 - i);
      logic [LW-1:0] lane_res;

      xau_slice #(
         .W              (LW),
         .TWO_STEP_CARRY (TWO_STEP_CARRY)
      ) u_slice (
         .a_i     (dst_i[LW-1:0]),
         .b_i     (src_i[LW-1:0]),
         .sub_i   (op_sub_i),
         .x_i     (x_now),
         .res_o   (lane_res),
         .flags_o (lane_flg[i])
      );

      if (LW == DATA_W) begin : g_full
         assign lane_wb[i] = lane_res;
      end else begin : g_merge
         assign lane_wb[i] = {dst_i[DATA_W-1:LW], lane_res};
      end
   end

   logic [DATA_W-1:0] sel_wb;
   xau_flag_s         sel_flg;

   always_comb begin
      unique case (xau_size_e'(size_i))
         XAU_SZ_BYTE: begin sel_wb = lane_wb[0]; sel_flg = lane_flg[0]; end
         XAU_SZ_WORD: begin sel_wb = lane_wb[1]; sel_flg = lane_flg[1]; end
         default:     begin sel_wb = lane_wb[2]; sel_flg = lane_flg[2]; end
      endcase
   end

   logic [DATA_W-1:0] result_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         result_q <= '0;
      end else if (valid_i) begin
         result_q <= sel_wb;
      end
   end

   assign result_o = result_q;

   xau_ccr u_ccr (
      .clk     (clk),
      .rst     (rst),
      .load_i  (valid_i),
      .flags_i (sel_flg),
      .ccr_o   (ccr_o)
   );

   // R10: result register holds without a strobe
   a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(result_o));

   // R11: reset clears the result
   a_r11_result_clear: assert property (@(posedge clk) rst |=> (result_o == '0));

   // R5: extend tracks carry after each operation
   a_r5_x_follows_c: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> (ccr_o[XAU_BIT_X] == ccr_o[XAU_BIT_C]));

   // R3: a byte operation keeps the upper destination bits
   a_r3_upper_keep: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i == XAU_SZ_BYTE) |=>
      (result_o[DATA_W-1:BYTE_W] == $past(dst_i[DATA_W-1:BYTE_W])));

   // R7: zero agrees with the registered byte result
   a_r7_zero_byte: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i == XAU_SZ_BYTE) |=>
      (ccr_o[XAU_BIT_Z] == (result_o[BYTE_W-1:0] == '0)));

   // R7: zero agrees with the registered long result
   a_r7_zero_long: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i[1]) |=> (ccr_o[XAU_BIT_Z] == (result_o == '0)));

   // R6: negative is the word result sign
   a_r6_neg_word: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i == XAU_SZ_WORD) |=>
      (ccr_o[XAU_BIT_N] == result_o[WORD_W-1]));

endmodule

// File: tb/xau_top_bench.sv
`timescale 1ns/1ps
module xau_top_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic        op_sub_i = 1'b0;
   logic [1:0]  size_i = 2'b00;
   logic [31:0] src_i = '0;
   logic [31:0] dst_i = '0;
   logic [31:0] result_o;
   logic [4:0]  ccr_o;

   always #2 clk = ~clk;

   xau_top u_xau_top (
      .clk      (clk),
      .rst      (rst),
      .valid_i  (valid_i),
      .op_sub_i (op_sub_i),
      .size_i   (size_i),
      .src_i    (src_i),
      .dst_i    (dst_i),
      .result_o (result_o),
      .ccr_o    (ccr_o)
   );

   typedef struct {
      logic [31:0] res;
      logic [4:0]  ccr;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   logic [4:0]  m_ccr = '0;
   logic [31:0] m_res = '0;
   bit          done = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model: layout X=4 N=3 Z=2 V=1 C=0
   task automatic model(input logic sub, input logic [1:0] sz,
                        input logic [31:0] d, input logic [31:0] s);
      int          w;
      logic [33:0] mask, full;
      logic [31:0] r;
      logic        sd, ss, sr, v, c;
      w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
      mask = (34'd1 << w) - 34'd1;
      if (sub) full = ({2'b0, d} & mask) - ({2'b0, s} & mask) - {33'd0, m_ccr[4]};
      else     full = ({2'b0, d} & mask) + ({2'b0, s} & mask) + {33'd0, m_ccr[4]};
      r  = full[31:0] & mask[31:0];
      c  = full[w];
      sd = d[w-1]; ss = s[w-1]; sr = r[w-1];
      v  = sub ? ((sd != ss) && (sr != sd)) : ((sd == ss) && (sr != sd));
      m_res = (d & ~mask[31:0]) | r;
      m_ccr = {c, sr, (r == 0), v, c};
   endtask

   task automatic do_op(input logic sub, input logic [1:0] sz,
                        input logic [31:0] d, input logic [31:0] s, input string tag);
      exp_t e;
      model(sub, sz, d, s);
      e.res = m_res; e.ccr = m_ccr; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      valid_i = 1'b1; op_sub_i = sub; size_i = sz; dst_i = d; src_i = s;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   // Monitor: compare each registered result against the scoreboard
   initial begin
      forever begin
         @(posedge clk);
         if (valid_i && !rst) begin
            #1;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL scoreboard underflow actual=%h expected=none", result_o);
            end else begin
               exp_t e;
               e = q.pop_front();
               check({e.tag, " result"}, result_o, e.res);
               check({e.tag, " ccr"}, {27'd0, ccr_o}, {27'd0, e.ccr});
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11 reset state
      check("R11 reset result", result_o, 32'h0);
      check("R11 reset ccr", {27'd0, ccr_o}, 32'h0);

      // R3 R4 word add with carry; upper bits kept
      do_op(1'b0, 2'b01, 32'hABCD_FFFF, 32'h0000_0001, "R3 R4 word add carry");
      // R1 R6 R8 byte 7F+7F+X(1) -> FF, ccr 0x0A
      do_op(1'b0, 2'b00, 32'h1234_567F, 32'h0000_007F, "R1 R6 R8 byte add ovf");
      do_op(1'b0, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001, "R4 R5 long add carry");
      // R7 R9 byte 80+7F+1 -> 00, ccr 0x15
      do_op(1'b0, 2'b00, 32'h0000_0080, 32'h0000_007F, "R7 R9 byte add zero");
      // R2 R8 byte FF-7F-1 -> 7F, ccr 0x02
      do_op(1'b1, 2'b00, 32'h0000_00FF, 32'h0000_007F, "R2 R8 byte sub ovf");
      do_op(1'b1, 2'b00, 32'h0000_0000, 32'h0000_0001, "R2 R4 byte sub borrow");
      // R2 R4 byte 00-7F-1 -> 80, ccr 0x19
      do_op(1'b1, 2'b00, 32'hFFFF_FF00, 32'h0000_007F, "R2 R4 byte sub borrow X");
      // R3 size 11 behaves as long
      do_op(1'b0, 2'b11, 32'h8000_0000, 32'h8000_0000, "R3 R8 wide add");
      do_op(1'b1, 2'b01, 32'h5555_8000, 32'h0000_0001, "R2 R8 word sub ovf");
      // R1 64-bit chain: 00000001_FFFFFFFF + 1
      do_op(1'b0, 2'b10, 32'h0, 32'h0, "R7 long zero clear X");
      do_op(1'b0, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001, "R1 chain low");
      do_op(1'b0, 2'b10, 32'h0000_0001, 32'h0000_0000, "R1 chain high");
      check("R1 chain high word", m_res, 32'h0000_0002);

      // R10 hold: inputs change with valid low
      @(negedge clk);
      op_sub_i = 1'b1; size_i = 2'b10; dst_i = 32'hDEAD_BEEF; src_i = 32'h1111_1111;
      repeat (2) @(negedge clk);
      check("R10 hold result", result_o, m_res);
      check("R10 hold ccr", {27'd0, ccr_o}, {27'd0, m_ccr});

      // Pseudo-random sequence chaining extend
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 60; i++) begin
         logic [31:0] a, b;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         a = lf;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         b = (i % 5 == 0) ? a : lf;
         do_op(i[0], i[2:1] ^ i[4:3], a, b, "R1 R2 R6 R7 R8 sweep");
      end

      // R11 mid-run reset
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_ccr = '0;
      check("R11 mid reset result", result_o, 32'h0);
      check("R11 mid reset ccr", {27'd0, ccr_o}, 32'h0);
      do_op(1'b0, 2'b00, 32'h0000_00FF, 32'h0000_0001, "R5 after reset");

      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule